// File: doc/BRIEF.md
# Timed-Wait Sequencer with Shared Down-Timer

This block steps a control state machine through a fixed sequence of eight timed phases and then returns to rest. Each phase lasts for a number of clock cycles that is set at elaboration time. The range runs from a single cycle up to 1024 cycles. Every cycle is counted on the one system clock, and no slower clock is derived.

The state register and the wait timer are separate. A single 10-bit timer serves all phases. By default it counts down by one on every clock and wraps from zero to its all-ones value. The control logic writes the next phase's preload into the timer on the same edge on which it changes phase. A phase ends when the timer reads zero. A preload of N therefore keeps a phase active for N+1 cycles.

The user supplies a start request. The block reports the active phase as a 4-bit code and as a one-hot vector. It also gives a one-cycle completion pulse when the last phase ends.

Top module: `timed_wait_sequencer`

## Requirements
- R1: A synchronous reset puts the machine at rest: the state code is 0 and the one-hot output is 9'b000000001. The completion pulse is low and the timer is zero.
- R2: At rest, with start low, the state code stays 0. If start is high at a rising edge while the code is 0, the code becomes 1 (the first phase) at that edge.
- R3: The phases are entered in the fixed order of codes 1, 2, 3, 4, 5, 6, 7 and 8. After code 8 the machine returns to code 0.
- R4: Phase k (code k, k = 1..8) stays active for exactly P[k-1]+1 cycles, where P[k-1] is the 10-bit field at bits [10*(k-1)+9 : 10*(k-1)] of the WAIT_PRELOADS parameter. A preload of 79 therefore gives an 80-cycle phase.
- R5: A preload of 0 gives a phase that is active for exactly one cycle, and a preload of 1023 gives a phase of 1024 cycles.
- R6: The completion output is high for exactly one cycle. That cycle is the first cycle in which the code is back to 0 after phase 8.
- R7: A start request while the code is 1..8 has no effect: the sequence neither restarts nor changes any phase length.
- R8: Bit i of the one-hot output is high exactly when the state code equals i (i = 0..8).
- R9: A start request in the cycle where the completion output is high is accepted. The code becomes 1 on the next edge, so runs can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a sequence; honoured only at rest |
| stateCode | output | 4 | Active state: 0 at rest, 1..8 for the timed phases |
| stateOneHot | output | 9 | One-hot form of stateCode |
| seqDone | output | 1 | One-cycle pulse when the machine returns to rest after phase 8 |

## Verification
The properties assume that reset is held for at least one rising edge before start is used. They also assume that start is a clean synchronous level sampled only at rising edges. They make no other assumption about when start is high. A request at any time must therefore be harmless or accepted, according to the state.

The bench drives start and reset only at falling edges. It begins with a long reset. It then deliberately raises start in the middle of a phase, in the completion cycle, and during reset, so that every start case the properties describe is actually reached.

// File: rtl/seq_pkg.sv
package seqPkg;
  localparam int NUM_WAITS  = 8;
  localparam int NUM_STATES = NUM_WAITS + 1;
  localparam int TIMER_W    = 10;
  localparam int CODE_W     = $clog2(NUM_STATES);
  localparam int SLOT_W     = $clog2(NUM_WAITS);

  localparam logic [CODE_W-1:0] REST_CODE = '0;
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_WAITS);

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
  } timerCmd_t;
endpackage

// File: rtl/seq_timer_path.sv
module seq_timer_path
  import seqPkg::*;
#(
  parameter logic [NUM_WAITS*TIMER_W-1:0] WAIT_PRELOADS = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  timerCmd_t             cmd,
  input  logic [CODE_W-1:0]     stateCode,
  output logic                  timerZero,
  output logic [TIMER_W-1:0]    timerVal,
  output logic [NUM_STATES-1:0] stateOneHot
);
  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] preloadSel;

  assign preloadSel = WAIT_PRELOADS[cmd.slot*TIMER_W +: TIMER_W];

  // Free-running down-count, wrapping; overridden by a load strobe
  always_ff @(posedge clk) begin
    if (rst)           timerQ <= '0;
    else if (cmd.load) timerQ <= preloadSel;
    else               timerQ <= timerQ - 1'b1;
  end

  assign timerZero = (timerQ == '0);
  assign timerVal  = timerQ;

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_decode
    assign stateOneHot[g] = (stateCode == CODE_W'(g));
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              timerZero,
  output timerCmd_t         cmd,
  output logic [CODE_W-1:0] stateCode,
  output logic              seqDone
);
  logic [CODE_W-1:0] stateQ, stateNext;
  logic              doneQ, doneNext;

  always_comb begin
    stateNext = stateQ;
    doneNext  = 1'b0;
    cmd       = '0;
    if (stateQ == REST_CODE) begin
      if (start) begin
        stateNext = CODE_W'(1);
        cmd.load  = 1'b1;
        cmd.slot  = '0;
      end
    end else if (timerZero) begin
      if (stateQ == LAST_CODE) begin
        stateNext = REST_CODE;
        doneNext  = 1'b1;
      end else begin
        stateNext = stateQ + 1'b1;
        cmd.load  = 1'b1;
        // code k uses slot k-1, so the successor's slot equals k
        cmd.slot  = SLOT_W'(stateQ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= REST_CODE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= doneNext;
    end
  end

  assign stateCode = stateQ;
  assign seqDone   = doneQ;
endmodule

// File: rtl/timed_wait_sequencer.sv
module timed_wait_sequencer
  import seqPkg::*;
#(
  parameter logic [NUM_WAITS*TIMER_W-1:0] WAIT_PRELOADS =
    {10'd63, 10'd200, 10'd511, 10'd40, 10'd150, 10'd1023, 10'd999, 10'd79}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic [CODE_W-1:0]     stateCode,
  output logic [NUM_STATES-1:0] stateOneHot,
  output logic                  seqDone
);
  timerCmd_t          timerCmd;
  logic               timerZero;
  logic [TIMER_W-1:0] timerVal;

  seq_control ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .timerZero (timerZero),
    .cmd       (timerCmd),
    .stateCode (stateCode),
    .seqDone   (seqDone)
  );

  seq_timer_path #(.WAIT_PRELOADS(WAIT_PRELOADS)) path_i (
    .clk         (clk),
    .rst         (rst),
    .cmd         (timerCmd),
    .stateCode   (stateCode),
    .timerZero   (timerZero),
    .timerVal    (timerVal),
    .stateOneHot (stateOneHot)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seqPkg::*;
#(
  parameter logic [TIMER_W-1:0] FIRST_PRELOAD = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [CODE_W-1:0]     stateCode,
  input logic [NUM_STATES-1:0] stateOneHot,
  input logic                  seqDone,
  input logic [TIMER_W-1:0]    timerVal
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stateCode == REST_CODE && timerVal == '0 && !seqDone));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (stateCode == REST_CODE && !start) |=> stateCode == REST_CODE);

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (stateCode == REST_CODE && start) |=> (stateCode == CODE_W'(1) && timerVal == FIRST_PRELOAD));

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (stateCode != REST_CODE && stateCode != LAST_CODE && timerVal == '0)
      |=> stateCode == CODE_W'($past(stateCode) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stateCode != REST_CODE && timerVal != '0)
      |=> (stateCode == $past(stateCode) && timerVal == TIMER_W'($past(timerVal) - 1'b1)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (stateCode == REST_CODE && !start && timerVal == '0) |=> timerVal == '1);

  p_done_r6: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> (stateCode == REST_CODE && $past(stateCode) == LAST_CODE));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    (stateCode != REST_CODE && timerVal != '0 && start) |=> stateCode == $past(stateCode));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot(stateOneHot) && stateOneHot[stateCode]);
endmodule

bind timed_wait_sequencer seq_checker #(
  .FIRST_PRELOAD(WAIT_PRELOADS[seqPkg::TIMER_W-1:0])
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .stateCode   (stateCode),
  .stateOneHot (stateOneHot),
  .seqDone     (seqDone),
  .timerVal    (timerVal)
);

// File: tb/timed_wait_sequencer_tb.sv
module timed_wait_sequencer_tb_top;
  // Bench preloads: phase k lasts PRE[k-1]+1 cycles
  localparam logic [79:0] BENCH_PRELOADS =
    {10'd40, 10'd2, 10'd5, 10'd20, 10'd1023, 10'd1, 10'd0, 10'd79};

  // Vector: {expected code, expected residency in cycles}
  localparam logic [15:0] VEC [8] = '{
    {4'd1, 12'd80}, {4'd2, 12'd1}, {4'd3, 12'd2}, {4'd4, 12'd1024},
    {4'd5, 12'd21}, {4'd6, 12'd6}, {4'd7, 12'd3}, {4'd8, 12'd41}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] stateCode;
  logic [8:0] stateOneHot;
  logic       seqDone;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  timed_wait_sequencer #(.WAIT_PRELOADS(BENCH_PRELOADS)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .stateCode(stateCode), .stateOneHot(stateOneHot), .seqDone(seqDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Walk the vector table; caller has just started a run (code 1 visible now).
  // inject: raise start for one cycle in the middle of each longer phase (R7).
  task automatic walkSequence(input bit inject);
    for (int v = 0; v < 8; v++) begin
      int cnt = 0;
      bit ohBad = 0;
      check("R3 phase order", int'(stateCode), int'(VEC[v][15:12]));
      while (stateCode == VEC[v][15:12] && cnt < 3000) begin
        if (stateOneHot != (9'd1 << stateCode)) ohBad = 1;
        if (seqDone) ohBad = 1;
        start = (inject && cnt == 1 && VEC[v][11:0] > 2) ? 1'b1 : 1'b0;
        cnt++;
        @(negedge clk);
      end
      start = 1'b0;
      check(inject ? "R7 residency with busy start" :
            (VEC[v][11:0] == 1 || VEC[v][11:0] == 1024) ? "R5 residency extreme" :
            "R4 residency", cnt, int'(VEC[v][11:0]));
      check("R8 one-hot tracks code", int'(ohBad), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 code after reset", int'(stateCode), 0);
    check("R1 one-hot after reset", int'(stateOneHot), 1);
    check("R1 done low after reset", int'(seqDone), 0);

    // R2 rest holds without start
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R2 rest holds", int'(stateCode), 0);
    end

    // R2 start accepted; first run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 start enters phase 1", int'(stateCode), 1);
    walkSequence(1'b0);
    check("R3 return to rest", int'(stateCode), 0);
    check("R6 done high at return", int'(seqDone), 1);

    // R9 back-to-back start in the done cycle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done lasts one cycle", int'(seqDone), 0);
    check("R9 back-to-back start", int'(stateCode), 1);

    // Second run with start pulses while busy
    walkSequence(1'b1);
    check("R6 done after second run", int'(seqDone), 1);
    @(negedge clk);
    check("R6 done falls", int'(seqDone), 0);
    check("R2 rest after run", int'(stateCode), 0);

    // R1 reset mid-sequence, start held high during reset
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check("R4 still in phase 1", int'(stateCode), 1);
    rst = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b0;
    check("R1 reset mid-run code", int'(stateCode), 0);
    check("R1 reset mid-run done", int'(seqDone), 0);
    @(negedge clk);
    check("R1 reset holds rest", int'(stateCode), 0);

    // One more full run from a fresh start
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    walkSequence(1'b0);
    check("R6 done after third run", int'(seqDone), 1);
    @(negedge clk);
    summary();
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
      summary();
    end
  end
endmodule